// File: doc/BRIEF.md
# Debug Mode Entry Sequencer

This block forces a target processor into its background debug mode and reports the outcome. After a start request it pulls the breakpoint, serial data-in and serial clock lines of the debug header low. It then holds the target's reset low for a time derived from the clock frequency, always at least 20 ms. When reset is released it watches the four processor status inputs for the pattern that shows the target has halted in debug mode.

The status inputs pass through a synchroniser. Success needs all four to read high on a number of consecutive samples before a settle window ends. Otherwise the attempt ends as a failure. On success, the serial clock and data-in lines are handed to the host and the target's data-out is routed back to it. The done and fail flags hold until the next start request. A start request that arrives while a sequence is running is ignored.

Top module: `dbg_entry_seq`

## Requirements
- R1: After reset: `busy_o`, `done_o`, `fail_o` and `reset_pull_o` are 0, and `bkpt_o`, `sdi_o`, `sclk_o` and `host_sdo_o` are 1.
- R2: A start request accepted while not busy sets `busy_o` on the next cycle. It drives `bkpt_o`, `sdi_o` and `sclk_o` low for exactly SETUP_CYC cycles before `reset_pull_o` rises.
- R3: `reset_pull_o` (1 = reset line pulled low; the line is never driven high) stays high for exactly ceil(CLK_HZ*HOLD_MS/1000) cycles, with HOLD_MS of at least 20. It is high at no other time.
- R4: `bkpt_o`, `sdi_o` and `sclk_o` remain low throughout the reset hold and the settle window.
- R5: After reset is released, `status_i` passes through SYNC_STAGES flops. The attempt succeeds on the first cycle j (j = 1 is the first edge after release) at which MATCH_CNT consecutive synchronised samples have all four bits `status_i[3:0]` equal to 1. `done_o` then rises and `busy_o` falls, and the settle phase lasts j cycles.
- R6: If no success occurs by cycle SETTLE_CYC after release, `fail_o` rises at that cycle. A sample with any status bit 0 breaks the run of matches.
- R7: `done_o` and `fail_o` are never high together, and each holds its value until the next accepted start request.
- R8: A start request while `busy_o` is high has no effect: the phase under way runs to its full length.
- R9: While `done_o` is high, `sclk_o` follows `host_sclk_i`, `sdi_o` follows `host_sdi_i`, `host_sdo_o` follows `tgt_sdo_i`, and `bkpt_o` is 1.
- R10: While `fail_o` is high, `bkpt_o`, `sdi_o`, `sclk_o` and `host_sdo_o` are 1 and `reset_pull_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin an entry attempt |
| status_i | input | STAT_W | Processor status lines from the target |
| host_sclk_i | input | 1 | Host serial clock, forwarded after success |
| host_sdi_i | input | 1 | Host serial data, forwarded after success |
| tgt_sdo_i | input | 1 | Target serial data-out |
| bkpt_o | output | 1 | Breakpoint request line, low = asserted |
| sdi_o | output | 1 | Serial data-in line to the target |
| sclk_o | output | 1 | Serial clock line to the target |
| reset_pull_o | output | 1 | Open-drain reset pull-down enable |
| host_sdo_o | output | 1 | Target data-out returned to the host |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sticky: debug mode entered |
| fail_o | output | 1 | Sticky: debug mode not entered |

## Verification
The assertions check these properties on every cycle:
- the reset pull is only ever preceded by the setup phase and only seen with the debug lines low;
- done and fail are mutually exclusive and hold their values;
- done only rises after a synchronised all-high sample;
- a start request in the hold phase never restarts the sequence.

Only the bench scenarios can show the exact phase lengths, the exact cycle at which the status pattern is accepted or the window runs out, and the correct handling of a status word with only some bits high. The same applies to the routing of the host and target serial lines after each outcome.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_HOLD   = 3'd2,
      ST_SETTLE = 3'd3,
      ST_PASS   = 3'd4,
      ST_FAIL   = 3'd5
   } seq_state_e;

endpackage

// File: rtl/dbg_sync.sv
module dbg_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dbg_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("dbg_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[0] <= '0;
            else         chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= '0;
            else         chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dbg_down_cnt.sv
module dbg_down_cnt #(
   parameter int WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [WIDTH-1:0] val_i,
   output logic             zero_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("dbg_down_cnt: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (load_i)         cnt_q <= val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // R3
   cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/dbg_run_cnt.sv
module dbg_run_cnt #(
   parameter int MATCH = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic en_i,
   input  logic hit_in_i,
   output logic hit_o
);

   localparam int RW = (MATCH < 2) ? 1 : $clog2(MATCH + 1);

   if (MATCH < 1) begin : g_bad_match
      $error("dbg_run_cnt: MATCH must be at least 1");
   end

   logic [RW-1:0] run_q;
   logic          last;

   assign last  = (run_q == RW'(MATCH - 1));
   assign hit_o = en_i && hit_in_i && last;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      run_q <= '0;
      else if (clr_i)   run_q <= '0;
      else if (en_i) begin
         if (!hit_in_i) run_q <= '0;
         else if (!last) run_q <= run_q + 1'b1;
      end
   end

   // R5
   run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q <= RW'(MATCH - 1));

   // R6
   run_break_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !clr_i && !hit_in_i) |=> (run_q == '0));

endmodule

// File: rtl/dbg_entry_seq.sv
module dbg_entry_seq
   import dbg_entry_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int HOLD_MS     = 20,
   parameter int SETUP_CYC   = 16,
   parameter int SETTLE_CYC  = 5000,
   parameter int MATCH_CNT   = 3,
   parameter int SYNC_STAGES = 2,
   parameter int STAT_W      = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [STAT_W-1:0] status_i,
   input  logic              host_sclk_i,
   input  logic              host_sdi_i,
   input  logic              tgt_sdo_i,
   output logic              bkpt_o,
   output logic              sdi_o,
   output logic              sclk_o,
   output logic              reset_pull_o,
   output logic              host_sdo_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              fail_o
);

   localparam longint unsigned HOLD_L =
      (longint'(CLK_HZ) * longint'(HOLD_MS) + 64'd999) / 64'd1000;
   localparam int HOLD_CYC = int'(HOLD_L);
   localparam int MAX_A    = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
   localparam int MAX_CYC  = (MAX_A > SETUP_CYC) ? MAX_A : SETUP_CYC;
   localparam int CW       = $clog2(MAX_CYC + 1);

   if (HOLD_MS < 20) begin : g_bad_hold
      $error("dbg_entry_seq: HOLD_MS must be at least 20");
   end
   if (CLK_HZ < 50) begin : g_bad_clk
      $error("dbg_entry_seq: CLK_HZ too small for a non-empty hold");
   end
   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("dbg_entry_seq: SETUP_CYC must be at least 1");
   end
   if (SETTLE_CYC < SYNC_STAGES + MATCH_CNT) begin : g_bad_settle
      $error("dbg_entry_seq: SETTLE_CYC shorter than sync plus match depth");
   end
   if (STAT_W < 1) begin : g_bad_w
      $error("dbg_entry_seq: STAT_W must be at least 1");
   end

   seq_state_e        st_q, st_d;
   logic              load;
   logic [CW-1:0]     load_val;
   logic              cnt_zero;
   logic [STAT_W-1:0] stat_sync;
   logic              all_high;
   logic              run_clr;
   logic              run_hit;
   logic              in_settle;
   logic              lines_low;
   logic              start_ok;

   dbg_sync #(.WIDTH(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (status_i),
      .q_o    (stat_sync)
   );

   dbg_down_cnt #(.WIDTH(CW)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .val_i  (load_val),
      .zero_o (cnt_zero)
   );

   assign all_high  = &stat_sync;
   assign in_settle = (st_q == ST_SETTLE);

   dbg_run_cnt #(.MATCH(MATCH_CNT)) u_run (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (run_clr),
      .en_i     (in_settle),
      .hit_in_i (all_high),
      .hit_o    (run_hit)
   );

   assign start_ok = start_i &&
                     (st_q == ST_IDLE || st_q == ST_PASS || st_q == ST_FAIL);

   always_comb begin
      st_d     = st_q;
      load     = 1'b0;
      load_val = '0;
      run_clr  = 1'b0;
      unique case (st_q)
         ST_IDLE, ST_PASS, ST_FAIL: begin
            if (start_ok) begin
               st_d     = ST_SETUP;
               load     = 1'b1;
               load_val = CW'(SETUP_CYC - 1);
            end
         end
         ST_SETUP: begin
            if (cnt_zero) begin
               st_d     = ST_HOLD;
               load     = 1'b1;
               load_val = CW'(HOLD_CYC - 1);
            end
         end
         ST_HOLD: begin
            if (cnt_zero) begin
               st_d     = ST_SETTLE;
               load     = 1'b1;
               load_val = CW'(SETTLE_CYC - 1);
               run_clr  = 1'b1;
            end
         end
         ST_SETTLE: begin
            if (run_hit)       st_d = ST_PASS;
            else if (cnt_zero) st_d = ST_FAIL;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= ST_IDLE;
      else         st_q <= st_d;
   end

   assign lines_low    = (st_q == ST_SETUP) || (st_q == ST_HOLD) || (st_q == ST_SETTLE);
   assign busy_o       = lines_low;
   assign done_o       = (st_q == ST_PASS);
   assign fail_o       = (st_q == ST_FAIL);
   assign reset_pull_o = (st_q == ST_HOLD);
   assign bkpt_o       = !lines_low;
   assign sclk_o       = done_o ? host_sclk_i : !lines_low;
   assign sdi_o        = done_o ? host_sdi_i  : !lines_low;
   assign host_sdo_o   = done_o ? tgt_sdo_i   : 1'b1;

   // R2
   setup_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(reset_pull_o) |-> $past(busy_o));

   // R4
   lines_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reset_pull_o |-> (!bkpt_o && !sdi_o && !sclk_o));

   // R3
   hold_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reset_pull_o && cnt_zero) |=> !reset_pull_o);

   // R7
   excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(done_o && fail_o));

   // R7
   done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !start_i) |=> done_o);

   // R7
   fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fail_o && !start_i) |=> fail_o);

   // R5
   pass_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_o) |-> $past(all_high));

   // R8
   no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_HOLD && start_i) |=> (st_q != ST_SETUP));

endmodule

// File: tb/tb_dbg_entry_seq.sv
module tb_dbg_entry_seq;

   localparam int CLK_PERIOD  = 10;
   localparam int CLK_HZ      = 1000;
   localparam int HOLD_MS     = 20;
   localparam int SETUP_CYC   = 4;
   localparam int SETTLE_CYC  = 24;
   localparam int MATCH_CNT   = 3;
   localparam int SYNC_STAGES = 2;
   localparam int HOLD_CYC    = (CLK_HZ * HOLD_MS + 999) / 1000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [3:0] status = 4'h0;
   logic       h_sclk = 1'b0, h_sdi = 1'b0, t_sdo = 1'b0;
   logic       bkpt, sdi, sclk, pull, h_sdo, busy, done, fail;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   logic [3:0] pat [SETTLE_CYC];

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_entry_seq #(
      .CLK_HZ(CLK_HZ), .HOLD_MS(HOLD_MS), .SETUP_CYC(SETUP_CYC),
      .SETTLE_CYC(SETTLE_CYC), .MATCH_CNT(MATCH_CNT),
      .SYNC_STAGES(SYNC_STAGES), .STAT_W(4)
   ) dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .status_i(status),
      .host_sclk_i(h_sclk), .host_sdi_i(h_sdi), .tgt_sdo_i(t_sdo),
      .bkpt_o(bkpt), .sdi_o(sdi), .sclk_o(sclk), .reset_pull_o(pull),
      .host_sdo_o(h_sdo), .busy_o(busy), .done_o(done), .fail_o(fail)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // expected outcome of the settle phase from the driven status pattern
   function automatic void model(output bit pass, output int len);
      int run = 0;
      pass = 1'b0;
      len  = SETTLE_CYC;
      for (int j = 1; j <= SETTLE_CYC; j++) begin
         int  idx = j - 1 - SYNC_STAGES;
         bit  s   = (idx >= 0) && (pat[idx] == 4'hF);
         run = s ? run + 1 : 0;
         if (run >= MATCH_CNT) begin
            pass = 1'b1;
            len  = j;
            return;
         end
      end
   endfunction

   task automatic fill_step(input int d, input logic [3:0] hi);
      for (int k = 0; k < SETTLE_CYC; k++) pat[k] = (k >= d) ? hi : 4'h0;
   endtask

   task automatic fill_rand();
      for (int k = 0; k < SETTLE_CYC; k++)
         pat[k] = (($urandom % 10) < 7) ? 4'hF : 4'($urandom % 15);
   endtask

   task automatic do_run(input bit poke_start);
      bit exp_pass;
      int exp_len;
      int su, h, k;
      model(exp_pass, exp_len);
      @(negedge clk);
      status = 4'h0;
      start  = 1'b1;
      @(negedge clk);
      start  = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
      su = 0;
      while (!pull && su < 100) begin
         chk(!bkpt && !sdi && !sclk, "R2 lines low in setup", int'({bkpt, sdi, sclk}), 0);
         su++;
         @(negedge clk);
      end
      chk(su == SETUP_CYC, "R2 setup length", su, SETUP_CYC);
      h = 0;
      while (pull && h < 1000) begin
         chk(!bkpt && !sdi && !sclk, "R4 lines low in hold", int'({bkpt, sdi, sclk}), 0);
         start = (poke_start && (h == 5 || h == 6)) ? 1'b1 : 1'b0;
         h++;
         @(negedge clk);
      end
      start = 1'b0;
      chk(h == HOLD_CYC, poke_start ? "R8 hold length with start poke" : "R3 hold length",
          h, HOLD_CYC);
      k = 0;
      while (busy && k < 1000) begin
         status = (k < SETTLE_CYC) ? pat[k] : 4'h0;
         chk(!bkpt && !sdi && !sclk && !pull, "R4 lines low in settle",
             int'({bkpt, sdi, sclk, pull}), 0);
         k++;
         @(negedge clk);
      end
      chk(k == exp_len, exp_pass ? "R5 settle length" : "R6 window length", k, exp_len);
      chk(done == exp_pass, "R5 done outcome", int'(done), int'(exp_pass));
      chk(fail == !exp_pass, "R6 fail outcome", int'(fail), int'(!exp_pass));
      status = 4'h0;
      repeat (3) @(negedge clk);
      chk(done == exp_pass && fail == !exp_pass, "R7 sticky result",
          int'({done, fail}), int'({exp_pass, !exp_pass}));
      if (exp_pass) begin
         for (int t = 0; t < 4; t++) begin
            h_sclk = t[0]; h_sdi = t[1]; t_sdo = ~t[0];
            #1;
            chk(sclk == h_sclk && sdi == h_sdi && h_sdo == t_sdo && bkpt,
                "R9 handover", int'({bkpt, sclk, sdi, h_sdo}),
                int'({1'b1, h_sclk, h_sdi, t_sdo}));
            @(negedge clk);
         end
      end else begin
         t_sdo = 1'b0;
         #1;
         chk(bkpt && sdi && sclk && h_sdo && !pull, "R10 released after fail",
             int'({bkpt, sdi, sclk, h_sdo, pull}), 30);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      void'($urandom(32'd7741));
      repeat (3) @(negedge clk);
      chk(!busy && !done && !fail && !pull, "R1 reset flags", int'({busy, done, fail, pull}), 0);
      chk(bkpt && sdi && sclk && h_sdo, "R1 reset lines", int'({bkpt, sdi, sclk, h_sdo}), 15);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !done && !fail, "R1 idle after reset", int'({busy, done, fail}), 0);
      fill_step(0, 4'hF);                                       do_run(1'b0);
      fill_step(SETTLE_CYC - SYNC_STAGES - MATCH_CNT, 4'hF);    do_run(1'b0);
      fill_step(SETTLE_CYC - SYNC_STAGES - MATCH_CNT + 1, 4'hF);do_run(1'b0);
      fill_step(SETTLE_CYC, 4'hF);                              do_run(1'b0);
      fill_step(0, 4'h7);                                       do_run(1'b0);
      fill_step(0, 4'hE);                                       do_run(1'b1);
      for (int k = 0; k < SETTLE_CYC; k++)
         pat[k] = ((k % MATCH_CNT) == MATCH_CNT - 1) ? 4'hB : 4'hF;
      do_run(1'b0);
      fill_step(2, 4'hF);                                       do_run(1'b1);
      for (int r = 0; r < 12; r++) begin
         fill_rand();
         do_run(r[0]);
      end
      summary();
   end

endmodule